// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

The unit watches a processor core for debug breakpoints and raises a debug interrupt with an exception vector that tells the two kinds of event apart. Four program counter breakpoint registers are compared against every PC the core presents. Their results are ORed into a single PC event. One data value register, together with a mask register, is compared against the data of every bus transaction.

A PC event is precise. The halt request is raised combinationally in the same cycle as the PC strobe, so the core can stop before the instruction at that address executes. The vector for this case is 13. A bus data event is imprecise. It only sets a pending flag, the core samples that flag like any other interrupt, and the vector is 12. The flag stays set until the core acknowledges it.

A trigger control register decides which event kinds act as first-level conditions and which act as second-level conditions. When any second-level condition is enabled, the unit works in two levels. A first-level event only arms the sequencer. The next second-level event fires the unit, and the kind of that final event picks the vector.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, halt_req, irq_pend and vector are all 0. All breakpoint registers and the trigger control register are zero, so no PC or bus input raises anything.
- R2: Register writes use select codes 0–3 for the PC breakpoint registers. Each PC breakpoint register holds an address in bits 31:1 and a valid bit in bit 0. A register with its valid bit clear never matches, and PC bit 0 takes no part in the compare.
- R3: The PC event is the OR of the matches of all four PC breakpoint registers, so a match in any one of them counts.
- R4: When an enabled PC event fires, halt_req is 1 and vector is 13. Both appear combinationally in the same cycle as the pc_valid strobe.
- R5: The data value is written with select code 4 and the mask with select code 5. A bus data bit is compared only where its mask bit is 0, and bits whose mask bit is 1 are ignored.
- R6: When an enabled bus event fires, irq_pend is 1 from the clock edge that samples the bus_valid strobe. While irq_pend is 1 and halt_req is 0, vector is 12. With neither set, vector is 0.
- R7: irq_pend stays 1 until a cycle with irq_ack, and reads 0 after that edge. A new bus event in the acknowledge cycle wins over the acknowledge.
- R8: The trigger control register has select code 6 and resets to zero. Its bit 2 enables PC events at the first level and bit 3 enables data events at the first level. Its bit 18 enables PC events at the second level and bit 19 enables data events at the second level. Two-level mode applies when bit 18 or bit 19 is set, and an event kind that is not enabled has no effect.
- R9: In two-level mode, a second-level event counts only after a first-level event has armed the sequencer. The arming event itself raises neither halt_req nor irq_pend.
- R10: In two-level mode, the kind of the second-level event that completes the sequence selects the vector. A PC event gives vector 13 with halt_req, and a bus event gives vector 12 with irq_pend.
- R11: The sequencer returns to the first level after it fires, after an irq_ack, and after a write to the trigger control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0–3 PC breakpoints, 4 data value, 5 data mask, 6 trigger control) |
| wr_data | input | 32 | Register write data |
| pc_valid | input | 1 | Core presents a PC this cycle |
| pc | input | 32 | Program counter |
| bus_valid | input | 1 | Bus transaction this cycle |
| bus_data | input | 32 | Bus transaction data |
| irq_ack | input | 1 | Core has taken the debug interrupt |
| halt_req | output | 1 | Precise halt before the instruction executes |
| irq_pend | output | 1 | Pending imprecise debug interrupt |
| vector | output | 8 | Exception vector number |

## Verification
The results are due at different times.
- Register writes take effect at the edge that samples them.
- halt_req and its vector 13 are due in the same cycle as the PC strobe. The bench drives the PC after a falling edge and samples one nanosecond later, before the next rising edge.
- irq_pend and vector 12 are due one edge after the bus strobe. The bench samples them at the falling edge that follows.
- Arming and level clears take effect one edge after their cause, so each follow-up probe is issued in a later cycle.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int VEC_W      = 8;
  localparam logic [VEC_W-1:0] VEC_PC   = 8'd13;
  localparam logic [VEC_W-1:0] VEC_BUS  = 8'd12;
  localparam logic [VEC_W-1:0] VEC_NONE = 8'd0;
  localparam int L1_BASE    = 2;
  localparam int L2_BASE    = 18;
  localparam int EN_PC      = 0;
  localparam int EN_DATA    = 1;

  typedef struct packed {
    logic data;
    logic pc;
  } trig_en_t;
endpackage

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp #(
  parameter int ADDR_W = 32,
  parameter int NUM_BP = 4
) (
  input  logic [NUM_BP-1:0][ADDR_W-1:0] bp_regs,
  input  logic                          pc_valid,
  input  logic [ADDR_W-1:0]             pc,
  output logic [NUM_BP-1:0]             hit_vec,
  output logic                          any_hit
);
  function automatic logic pc_bp_hit(input logic [ADDR_W-1:0] bp,
                                     input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] diff;
    diff = (bp ^ addr) >> 1;
    return bp[0] && (diff == '0);
  endfunction

  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    assign hit_vec[i] = pc_valid && pc_bp_hit(bp_regs[i], pc);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dval,
  input  logic [DATA_W-1:0] dmask,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  output logic              hit
);
  function automatic logic masked_eq(input logic [DATA_W-1:0] v,
                                     input logic [DATA_W-1:0] m,
                                     input logic [DATA_W-1:0] d);
    return ((v ^ d) & ~m) == '0;
  endfunction

  assign hit = bus_valid && masked_eq(dval, dmask, bus_data);
endmodule

// File: rtl/dbg_level_seq.sv
module dbg_level_seq
  import dbg_trig_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  trig_en_t l1_en,
  input  trig_en_t l2_en,
  input  logic     pc_hit,
  input  logic     bus_hit,
  input  logic     clear,
  output logic     fire_pc,
  output logic     fire_bus,
  output logic     arm,
  output logic     level,
  output logic     two_level
);
  logic ev_pc_l1, ev_bus_l1, ev_pc_l2, ev_bus_l2;

  assign two_level = l2_en.pc || l2_en.data;
  assign ev_pc_l1  = pc_hit  && l1_en.pc;
  assign ev_bus_l1 = bus_hit && l1_en.data;
  assign ev_pc_l2  = pc_hit  && l2_en.pc;
  assign ev_bus_l2 = bus_hit && l2_en.data;

  always_comb begin
    fire_pc  = 1'b0;
    fire_bus = 1'b0;
    arm      = 1'b0;
    if (!two_level) begin
      fire_pc  = ev_pc_l1;
      fire_bus = ev_bus_l1;
    end else if (!level) begin
      arm = ev_pc_l1 || ev_bus_l1;
    end else begin
      fire_pc  = ev_pc_l2;
      fire_bus = ev_bus_l2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             level <= 1'b0;
    else if (clear || fire_pc || fire_bus)  level <= 1'b0;
    else if (arm)                           level <= 1'b1;
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_PCBP = 4,
  localparam int SEL_W   = $clog2(NUM_PCBP + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              irq_ack,
  output logic              halt_req,
  output logic              irq_pend,
  output logic [VEC_W-1:0]  vector
);
  localparam logic [SEL_W-1:0] SEL_DVAL  = SEL_W'(NUM_PCBP);
  localparam logic [SEL_W-1:0] SEL_DMASK = SEL_W'(NUM_PCBP + 1);
  localparam logic [SEL_W-1:0] SEL_CTRL  = SEL_W'(NUM_PCBP + 2);

  logic [NUM_PCBP-1:0][ADDR_W-1:0] bp_regs;
  logic [DATA_W-1:0] dval, dmask;
  trig_en_t l1_en, l2_en;
  logic [NUM_PCBP-1:0] pc_hit_vec;
  logic pc_hit, bus_hit;
  logic fire_pc, fire_bus, arm, level, two_level;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  for (genvar i = 0; i < NUM_PCBP; i++) begin : g_bp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bp_regs[i] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i)))
        bp_regs[i] <= ADDR_W'(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dval  <= '0;
      dmask <= '0;
      l1_en <= '0;
      l2_en <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_DVAL)  dval  <= DATA_W'(wr_data);
      if (wr_sel == SEL_DMASK) dmask <= DATA_W'(wr_data);
      if (wr_sel == SEL_CTRL) begin
        l1_en.pc   <= wr_data[L1_BASE + EN_PC];
        l1_en.data <= wr_data[L1_BASE + EN_DATA];
        l2_en.pc   <= wr_data[L2_BASE + EN_PC];
        l2_en.data <= wr_data[L2_BASE + EN_DATA];
      end
    end
  end

  dbg_pc_cmp #(.ADDR_W(ADDR_W), .NUM_BP(NUM_PCBP)) u_pc_cmp (
    .bp_regs (bp_regs),
    .pc_valid(pc_valid),
    .pc      (pc),
    .hit_vec (pc_hit_vec),
    .any_hit (pc_hit)
  );

  dbg_data_cmp #(.DATA_W(DATA_W)) u_data_cmp (
    .dval     (dval),
    .dmask    (dmask),
    .bus_valid(bus_valid),
    .bus_data (bus_data),
    .hit      (bus_hit)
  );

  dbg_level_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .l1_en    (l1_en),
    .l2_en    (l2_en),
    .pc_hit   (pc_hit),
    .bus_hit  (bus_hit),
    .clear    (ctrl_wr || irq_ack),
    .fire_pc  (fire_pc),
    .fire_bus (fire_bus),
    .arm      (arm),
    .level    (level),
    .two_level(two_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_pend <= 1'b0;
    else if (fire_bus) irq_pend <= 1'b1;
    else if (irq_ack)  irq_pend <= 1'b0;
  end

  assign halt_req = fire_pc;
  assign vector   = fire_pc ? VEC_PC : (irq_pend ? VEC_BUS : VEC_NONE);
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pc_valid,
  input logic       bus_valid,
  input logic       irq_ack,
  input logic       halt_req,
  input logic       irq_pend,
  input logic [7:0] vector,
  input logic       fire_pc,
  input logic       fire_bus,
  input logic       level,
  input logic       two_level,
  input logic       ctrl_wr
);
  p_halt_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> vector == 8'd13);

  p_halt_pcv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> pc_valid);

  p_pend_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(bus_valid));

  p_pend_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !halt_req) |-> vector == 8'd12);

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !fire_bus) |=> !irq_pend);

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);

  p_l2_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (two_level && (fire_pc || fire_bus)) |-> level);

  p_level_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr || irq_ack || fire_pc || fire_bus) |=> !level);
endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc_valid (pc_valid),
  .bus_valid(bus_valid),
  .irq_ack  (irq_ack),
  .halt_req (halt_req),
  .irq_pend (irq_pend),
  .vector   (vector),
  .fire_pc  (fire_pc),
  .fire_bus (fire_bus),
  .level    (level),
  .two_level(two_level),
  .ctrl_wr  (ctrl_wr)
);

// File: tb/tb_dbg_trig_unit.sv
`timescale 1ns/100ps
module tb_dbg_trig_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_data = '0;
  logic        irq_ack = 1'b0;
  logic        halt_req, irq_pend;
  logic [7:0]  vector;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [31:0] C_L1_PC   = 32'h1 << 2;
  localparam logic [31:0] C_L1_DATA = 32'h1 << 3;
  localparam logic [31:0] C_L2_PC   = 32'h1 << 18;
  localparam logic [31:0] C_L2_DATA = 32'h1 << 19;

  always #2.5 clk = ~clk;

  dbg_trig_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_valid(pc_valid), .pc(pc), .bus_valid(bus_valid), .bus_data(bus_data),
    .irq_ack(irq_ack), .halt_req(halt_req), .irq_pend(irq_pend), .vector(vector)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pc_probe(input logic [31:0] addr, output logic h, output logic [7:0] v);
    @(negedge clk);
    pc_valid = 1'b1; pc = addr;
    #1;
    h = halt_req; v = vector;
    @(negedge clk);
    pc_valid = 1'b0;
  endtask

  task automatic bus_probe(input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic h; logic [7:0] v;
    check("R1", "halt after reset", halt_req, 0);
    check("R1", "pend after reset", irq_pend, 0);
    check("R1", "vector after reset", vector, 0);
    pc_probe(32'h0, h, v);
    check("R1", "pc 0 after reset", h, 0);
    bus_probe(32'h0);
    check("R1", "bus 0 after reset", irq_pend, 0);
  endtask

  task automatic t_pc_single();
    logic h; logic [7:0] v;
    wr(3'd0, 32'h0000_1001);
    wr(3'd6, C_L1_PC);
    pc_probe(32'h0000_1000, h, v);
    check("R4", "halt on match", h, 1);
    check("R4", "vector on match", v, 13);
    pc_probe(32'h0000_1001, h, v);
    check("R2", "pc bit0 ignored", h, 1);
    pc_probe(32'h0000_1002, h, v);
    check("R2", "mismatch no halt", h, 0);
    check("R6", "idle vector", v, 0);
  endtask

  task automatic t_or();
    logic h; logic [7:0] v;
    wr(3'd2, 32'h0000_2001);
    wr(3'd1, 32'h0000_4001);
    wr(3'd3, 32'h0000_3000);
    pc_probe(32'h0000_2000, h, v);
    check("R3", "bp2 hit", h, 1);
    pc_probe(32'h0000_4000, h, v);
    check("R3", "bp1 hit", h, 1);
    pc_probe(32'h0000_3000, h, v);
    check("R2", "invalid bp3 no hit", h, 0);
  endtask

  task automatic t_data_mask();
    wr(3'd4, 32'hA5A5_0000);
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd6, C_L1_DATA);
    bus_probe(32'hA5A5_1234);
    check("R5", "masked match pend", irq_pend, 1);
    check("R6", "bus vector", vector, 12);
    @(negedge clk);
    check("R7", "pend held", irq_pend, 1);
    ack();
    check("R7", "ack clears", irq_pend, 0);
    bus_probe(32'hA5A4_0000);
    check("R5", "unmasked bit differs", irq_pend, 0);
    wr(3'd6, C_L1_PC);
    bus_probe(32'hA5A5_0000);
    check("R8", "data disabled ignored", irq_pend, 0);
  endtask

  task automatic t_two_pc_then_bus();
    logic h; logic [7:0] v;
    wr(3'd6, C_L1_PC | C_L2_DATA);
    bus_probe(32'hA5A5_0000);
    check("R9", "l2 before arm ignored", irq_pend, 0);
    pc_probe(32'h0000_1000, h, v);
    check("R9", "arming pc no halt", h, 0);
    check("R9", "arming pc no pend", irq_pend, 0);
    bus_probe(32'hA5A5_0000);
    check("R10", "bus completes pend", irq_pend, 1);
    check("R10", "bus completes vector", vector, 12);
    ack();
    bus_probe(32'hA5A5_0000);
    check("R11", "level reset after fire", irq_pend, 0);
  endtask

  task automatic t_two_bus_then_pc();
    logic h; logic [7:0] v;
    wr(3'd6, C_L1_DATA | C_L2_PC);
    pc_probe(32'h0000_1000, h, v);
    check("R9", "pc before arm", h, 0);
    bus_probe(32'hA5A5_0000);
    check("R9", "arming bus no pend", irq_pend, 0);
    pc_probe(32'h0000_1000, h, v);
    check("R10", "pc completes halt", h, 1);
    check("R10", "pc completes vector", v, 13);
    pc_probe(32'h0000_1000, h, v);
    check("R11", "level reset after halt", h, 0);
  endtask

  task automatic t_clears();
    logic h; logic [7:0] v;
    bus_probe(32'hA5A5_0000);
    wr(3'd6, C_L1_DATA | C_L2_PC);
    pc_probe(32'h0000_1000, h, v);
    check("R11", "ctrl write clears level", h, 0);
    bus_probe(32'hA5A5_0000);
    ack();
    pc_probe(32'h0000_1000, h, v);
    check("R11", "ack clears level", h, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pc_single();
    t_or();
    t_data_mask();
    t_two_pc_then_bus();
    t_two_bus_then_pc();
    t_clears();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule